// File: doc/BRIEF.md
# Alert Interrupt and Alert-Response Responder

This block owns the interrupt line of a multi-channel temperature monitor. It combines the out-of-limit flags of the on-die channel and two remote channels, plus a flag for an open-circuit remote sensor, with the mask bits held in two configuration bytes. Any fault that passes the masks sets a sticky alert. The alert drives an active-low, open-drain line, so several monitors can share one wired-OR interrupt wire. The block's output is the enable of the pull-down transistor.

The block also answers the bus master's alert-response query. It watches decoded events from a bit-level two-wire slave front end: start, stop, a received address with its read flag, and each rising clock edge together with the sampled data level. A read to the alert response address (7-bit `0001100`) is acknowledged only while this device's alert is set. The block then sends a byte that holds its own 7-bit address in the upper bits and a 1 in the LSB. During that byte it compares each bit on the wire with the bit it sent. When it loses to a lower address, it lets go of the data line for the rest of the byte. A device that sends the whole byte has won. When it wins, the alert clears if no fault remains. A fault that is still present keeps the alert set, so the device answers the next query again.

Top module: `smb_alert_top`

## Requirements
- R1: `alert_pull_o` goes to 1 (line pulled low) at the first clock edge after any out-of-limit flag (`lim_local_i`, `lim_remote_i[0]`, `lim_remote_i[1]`) is 1 while that flag is unmasked.
- R2: An open remote sensor (`open_i`=1) sets the alert at the next edge unless the global mask is set.
- R3: Mask positions: `consec_i[5]` masks the local channel, `cfg_i[1]` masks remote 0, `cfg_i[0]` masks remote 1, and `cfg_i[7]` masks every source. All other bits of both bytes have no effect.
- R4: Once set, the alert stays set after the fault goes away, until this device wins an alert-response byte.
- R5: When the front end reports an address of `0001100` with read flag 1 while the alert is set, `addr_ack_o` is 1 from the next cycle until the next scl rising strobe. There is no acknowledge when the alert is clear, when the flag is write, or for any other address.
- R6: After that acknowledge strobe, the byte `{DEV_ADDR,1}` is sent MSB first. `sda_pull_o` is 1 exactly while the current bit is 0, and each `scl_rise_i` moves to the next bit.
- R7: If the device sends a 1 and samples a 0, it has lost. `sda_pull_o` stays 0 for the rest of the byte, `arb_lost_o` is 1, and the alert stays set.
- R8: After all 8 bits are sent without loss, `won_o` is 1. At that same edge the alert clears if no unmasked fault is present; otherwise it stays set.
- R9: A start or stop event returns the responder to idle at the next edge: `addr_ack_o`, `sda_pull_o`, `won_o` and `arb_lost_o` are all 0.
- R10: During and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| lim_local_i | input | 1 | on-die channel out of limit |
| lim_remote_i | input | 2 | remote channels out of limit (bit 0 = remote 0) |
| open_i | input | 1 | remote sensor open circuit |
| cfg_i | input | 8 | configuration byte holding the remote and global masks |
| consec_i | input | 8 | byte holding the local mask |
| ev_start_i | input | 1 | start condition strobe |
| ev_stop_i | input | 1 | stop condition strobe |
| ev_addr_i | input | 1 | address byte received strobe |
| addr_i | input | 7 | received 7-bit address |
| rd_i | input | 1 | received read flag |
| scl_rise_i | input | 1 | scl rising edge strobe |
| sda_i | input | 1 | data line level sampled at that edge |
| alert_pull_o | output | 1 | enable of the alert pull-down |
| addr_ack_o | output | 1 | acknowledge the alert-response address |
| sda_pull_o | output | 1 | enable of the data line pull-down |
| won_o | output | 1 | response byte sent without loss |
| arb_lost_o | output | 1 | arbitration lost in the response byte |

## Verification
Every registered result appears at the first clock edge after its stimulus. The alert follows a flag or mask change one edge later. `addr_ack_o` rises one edge after the address strobe. Each `scl_rise_i` strobe moves `sda_pull_o` to the next bit one edge later. `won_o` and the alert release take effect at the edge of the last bit. The bench drives inputs on falling edges and checks at the next falling edge, so each check sees exactly one rising edge after its stimulus. Reset release goes through a two-stage synchronizer, so the bench waits three cycles after reset before it drives anything.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned REG_W  = 8;

  localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

  localparam int unsigned LOCAL_MASK_BIT  = 5;
  localparam int unsigned GLOBAL_MASK_BIT = 7;

  typedef enum logic [2:0] {
    RSP_IDLE,
    RSP_ACK,
    RSP_SEND,
    RSP_LOST,
    RSP_WON
  } rsp_state_e;

  function automatic int unsigned remote_mask_bit(input int unsigned idx);
    int unsigned pos;
    case (idx)
      0:       pos = 1;
      default: pos = 0;
    endcase
    return pos;
  endfunction

endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/smb_alert_cause.sv
module smb_alert_cause
  import smb_alert_pkg::*;
#(
  parameter int unsigned N_REMOTE = 2
) (
  input  logic                lim_local,
  input  logic [N_REMOTE-1:0] lim_remote,
  input  logic                open_sensor,
  input  logic [REG_W-1:0]    cfg,
  input  logic [REG_W-1:0]    consec,
  output logic                cause
);

  logic [N_REMOTE-1:0] remote_hit;

  for (genvar g = 0; g < N_REMOTE; g++) begin : g_remote
    assign remote_hit[g] = lim_remote[g] & ~cfg[remote_mask_bit(g)];
  end

  logic local_hit;
  assign local_hit = lim_local & ~consec[LOCAL_MASK_BIT];

  always_comb begin
    cause = local_hit | (|remote_hit) | open_sensor;
    if (cfg[GLOBAL_MASK_BIT]) cause = 1'b0;
  end

endmodule

// File: rtl/smb_alert_hold.sv
module smb_alert_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  input  logic win,
  output logic alert
);

  logic alert_q, alert_d, alert_en;

  always_comb begin
    alert_d  = alert_q;
    alert_en = 1'b0;
    if (cause) begin
      alert_d  = 1'b1;
      alert_en = !alert_q;
    end else if (win) begin
      alert_d  = 1'b0;
      alert_en = alert_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alert_q <= 1'b0;
    else if (alert_en) alert_q <= alert_d;
  end

  assign alert = alert_q;

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_alert_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              scl_rise,
  input  logic              sda,
  input  logic              alert_on,
  output logic              addr_ack,
  output logic              sda_pull,
  output logic              won,
  output logic              lost,
  output logic              win_now
);

  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] TX_BYTE = {DEV_ADDR, 1'b1};
  localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(BYTE_W - 1);

  rsp_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             tx_bit, lose_now, ara_hit;

  assign tx_bit   = TX_BYTE[idx_q];
  assign lose_now = tx_bit & ~sda;
  assign ara_hit  = ev_addr & (addr == ARA_ADDR) & rd & alert_on;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    win_now = 1'b0;
    if (ev_start || ev_stop) begin
      state_d = RSP_IDLE;
    end else begin
      case (state_q)
        RSP_IDLE: if (ara_hit) state_d = RSP_ACK;
        RSP_ACK: begin
          if (scl_rise) begin
            state_d = RSP_SEND;
            idx_d   = IDX_TOP;
            idx_en  = 1'b1;
          end
        end
        RSP_SEND: begin
          if (scl_rise) begin
            if (lose_now) begin
              state_d = RSP_LOST;
            end else if (idx_q == '0) begin
              state_d = RSP_WON;
              win_now = 1'b1;
            end else begin
              idx_d  = idx_q - 1'b1;
              idx_en = 1'b1;
            end
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RSP_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign addr_ack = (state_q == RSP_ACK);
  assign sda_pull = (state_q == RSP_SEND) & ~tx_bit;
  assign won      = (state_q == RSP_WON);
  assign lost     = (state_q == RSP_LOST);

endmodule

// File: rtl/smb_alert_top.sv
module smb_alert_top
  import smb_alert_pkg::*;
#(
  parameter int unsigned       N_REMOTE = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h4C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lim_local_i,
  input  logic [N_REMOTE-1:0] lim_remote_i,
  input  logic                open_i,
  input  logic [REG_W-1:0]    cfg_i,
  input  logic [REG_W-1:0]    consec_i,
  input  logic                ev_start_i,
  input  logic                ev_stop_i,
  input  logic                ev_addr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                scl_rise_i,
  input  logic                sda_i,
  output logic                alert_pull_o,
  output logic                addr_ack_o,
  output logic                sda_pull_o,
  output logic                won_o,
  output logic                arb_lost_o
);

  logic rst_q_n;
  logic cause, win_now, alert;

  smb_rst_sync #(.STAGES(2)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  smb_alert_cause #(.N_REMOTE(N_REMOTE)) cause_i (
    .lim_local  (lim_local_i),
    .lim_remote (lim_remote_i),
    .open_sensor(open_i),
    .cfg        (cfg_i),
    .consec     (consec_i),
    .cause      (cause)
  );

  smb_alert_hold hold_i (
    .clk  (clk),
    .rst_n(rst_q_n),
    .cause(cause),
    .win  (win_now),
    .alert(alert)
  );

  smb_ara_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ev_start(ev_start_i),
    .ev_stop (ev_stop_i),
    .ev_addr (ev_addr_i),
    .addr    (addr_i),
    .rd      (rd_i),
    .scl_rise(scl_rise_i),
    .sda     (sda_i),
    .alert_on(alert),
    .addr_ack(addr_ack_o),
    .sda_pull(sda_pull_o),
    .won     (won_o),
    .lost    (arb_lost_o),
    .win_now (win_now)
  );

  assign alert_pull_o = alert;

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk
  import smb_alert_pkg::*;
#(
  parameter int unsigned N_REMOTE = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lim_local_i,
  input logic [N_REMOTE-1:0] lim_remote_i,
  input logic                open_i,
  input logic [REG_W-1:0]    cfg_i,
  input logic [REG_W-1:0]    consec_i,
  input logic                ev_start_i,
  input logic                ev_stop_i,
  input logic                ev_addr_i,
  input logic                scl_rise_i,
  input logic                alert_pull_o,
  input logic                addr_ack_o,
  input logic                sda_pull_o,
  input logic                won_o,
  input logic                arb_lost_o
);

  assert_local_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_local_i && !consec_i[5] && !cfg_i[7]) |=> alert_pull_o);

  assert_open_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !cfg_i[7]) |=> alert_pull_o);

  assert_ack_needs_alert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ack_o) |-> ($past(alert_pull_o) && $past(ev_addr_i)));

  assert_loss_on_released_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost_o) |-> ($past(scl_rise_i) && !$past(sda_pull_o)));

  assert_release_only_on_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull_o) |-> $rose(won_o));

  assert_outputs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_ack_o, sda_pull_o, won_o, arb_lost_o}));

  assert_idle_after_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_i || ev_stop_i) |=> !(addr_ack_o || sda_pull_o || won_o || arb_lost_o));

endmodule

bind smb_alert_top smb_alert_chk #(.N_REMOTE(N_REMOTE)) chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .lim_local_i (lim_local_i),
  .lim_remote_i(lim_remote_i),
  .open_i      (open_i),
  .cfg_i       (cfg_i),
  .consec_i    (consec_i),
  .ev_start_i  (ev_start_i),
  .ev_stop_i   (ev_stop_i),
  .ev_addr_i   (ev_addr_i),
  .scl_rise_i  (scl_rise_i),
  .alert_pull_o(alert_pull_o),
  .addr_ack_o  (addr_ack_o),
  .sda_pull_o  (sda_pull_o),
  .won_o       (won_o),
  .arb_lost_o  (arb_lost_o)
);

// File: tb/smb_alert_top_tb_top.sv
`timescale 1ns/1ps
module smb_alert_top_tb_top;

  localparam logic [6:0] DEV = 7'h4C;
  localparam logic [6:0] ARA = 7'b0001100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lim_local_i;
  logic [1:0] lim_remote_i;
  logic       open_i;
  logic [7:0] cfg_i, consec_i;
  logic       ev_start_i, ev_stop_i, ev_addr_i, rd_i, scl_rise_i, sda_i;
  logic [6:0] addr_i;
  logic       alert_pull_o, addr_ack_o, sda_pull_o, won_o, arb_lost_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  smb_alert_top #(.N_REMOTE(2), .DEV_ADDR(DEV)) dut_i (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    lim_local_i = 0; lim_remote_i = 0; open_i = 0; cfg_i = 0; consec_i = 0;
    ev_start_i = 0; ev_stop_i = 0; ev_addr_i = 0; addr_i = 0; rd_i = 0;
    scl_rise_i = 0; sda_i = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_event(input bit is_stop);
    if (is_stop) ev_stop_i = 1; else ev_start_i = 1;
    step();
    ev_stop_i = 0; ev_start_i = 0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic r);
    bus_event(0);
    ev_addr_i = 1; addr_i = a; rd_i = r;
    step();
    ev_addr_i = 0;
  endtask

  task automatic run_ara(input logic [6:0] rival, input bit with_rival, output bit lost);
    logic [7:0] mine, theirs;
    logic bus;
    mine = {DEV, 1'b1};
    theirs = {rival, 1'b1};
    lost = 0;
    send_addr(ARA, 1'b1);
    chk(addr_ack_o, 1'b1, "R5 ack on alert-response read");
    sda_i = 0; scl_rise_i = 1;
    step();
    scl_rise_i = 0;
    for (int b = 7; b >= 0; b--) begin
      chk(sda_pull_o, !lost && !mine[b], "R6 data bit drive");
      bus = (lost ? 1'b1 : mine[b]) & (with_rival ? theirs[b] : 1'b1);
      if (!lost && mine[b] && !bus) lost = 1;
      sda_i = bus; scl_rise_i = 1;
      step();
      scl_rise_i = 0; sda_i = 1;
    end
    chk(arb_lost_o, lost, "R7 loss flag");
    chk(won_o, !lost, "R8 win flag");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit lost;
    rst_n = 0;
    clear_inputs();
    do_reset();
    // R10 reset state
    chk(alert_pull_o, 0, "R10 alert"); chk(addr_ack_o, 0, "R10 ack");
    chk(sda_pull_o, 0, "R10 sda"); chk(won_o, 0, "R10 won"); chk(arb_lost_o, 0, "R10 lost");

    // R1 R2 R3: exhaustive sweep of four fault flags by four mask bits
    for (int v = 0; v < 256; v++) begin
      logic l, r0, r1, op, ml, m0, m1, g, exp;
      do_reset();
      {g, ml, m0, m1, op, r1, r0, l} = 8'(v);
      lim_local_i = l; lim_remote_i = {r1, r0}; open_i = op;
      cfg_i = {g, 5'(~v), m0, m1};
      consec_i = {2'(v), ml, 5'(~v >> 2)};
      exp = !g && ((l && !ml) || (r0 && !m0) || (r1 && !m1) || op);
      step();
      chk(alert_pull_o, exp, "R1 R2 R3 mask sweep");
    end

    // R4 sticky alert
    do_reset();
    lim_local_i = 1; step();
    lim_local_i = 0; repeat (5) step();
    chk(alert_pull_o, 1, "R4 alert held after fault gone");

    // R5 no ack for write or other address
    send_addr(ARA, 1'b0);
    chk(addr_ack_o, 0, "R5 no ack on write");
    send_addr(7'h0D, 1'b1);
    chk(addr_ack_o, 0, "R5 no ack other address");
    bus_event(1);

    // R8 win with fault gone clears alert
    run_ara(7'h00, 0, lost);
    chk(alert_pull_o, 0, "R8 alert released");
    bus_event(1);
    chk(won_o, 0, "R9 stop clears win");

    // R5 alert clear: no response
    send_addr(ARA, 1'b1);
    chk(addr_ack_o, 0, "R5 no ack without alert");
    bus_event(1);

    // R8 win with fault present keeps alert; device answers again
    open_i = 1; step();
    run_ara(7'h4D, 1, lost);
    chk(alert_pull_o, 1, "R8 alert kept while fault present");
    bus_event(1);
    run_ara(7'h4E, 1, lost);
    chk(alert_pull_o, 1, "R8 second response");
    bus_event(1);

    // R7 lose to a lower address
    open_i = 0; step();
    run_ara(7'h18, 1, lost);
    chk(lost, 1, "R7 bench expects loss");
    chk(sda_pull_o, 0, "R7 released after loss");
    chk(alert_pull_o, 1, "R7 alert kept after loss");
    bus_event(1);
    chk(arb_lost_o, 0, "R9 stop clears loss");

    // R9 start in the middle of the byte
    send_addr(ARA, 1'b1);
    sda_i = 0; scl_rise_i = 1; step(); scl_rise_i = 0; sda_i = 1;
    scl_rise_i = 1; step(); scl_rise_i = 0;
    chk(sda_pull_o, 1, "R6 second bit of 0x99 is 0");
    bus_event(0);
    chk(sda_pull_o, 0, "R9 start returns to idle");
    chk(addr_ack_o, 0, "R9 no ack after start");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule